// File: doc/BRIEF.md
# ADC Multichannel Scan Sequencer

This block sequences an analog-to-digital converter through a group of input channels and keeps looping over that group until software stops it. A small control register holds a run bit, an interrupt enable, a pass-complete flag and a channel-selection field made of a group bit and a channel count. The run bit can be set by a register write, by a timer trigger pulse or by an external trigger pulse.

While the block runs, it holds a conversion request to the converter and presents the channel number. Each time the converter reports completion, the block stores the returned sample in that channel's own result slot. It then moves straight on to the next channel in the same cycle, so the request never drops between channels. After the last channel of the group, the block sets the flag and starts again from the group's first channel. The interrupt output is the flag gated by the enable.

Clearing the run bit stops the block at once. A conversion that is still in flight is dropped. The next start always begins at the group's first channel.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `ctl_rd` reads 0, `conv_req` and `irq` are low, and every result slot holds 0.
- R2: The run bit (`ctl_wdata[0]`) becomes 1 on a write with bit 0 set, on a `tmr_trig` pulse or on an `ext_trig` pulse. From the next cycle, `conv_req` is high and `conv_ch` is the first channel of the selected group.
- R3: Channel field encoding:
  - bit 5 picks the group: 0 selects channels 0..3, 1 selects channels 4..7.
  - bits 4:3 hold n, and n+1 channels of the group are scanned.
  - `conv_ch` = 4*group + index.
- R4: When `conv_done` is seen while the block runs, `conv_req` stays high and `conv_ch` moves to the next channel in the following cycle.
- R5: The `conv_data` value taken with `conv_done` is stored in the result slot of the current channel. That slot is `res_flat[ch*10 +: 10]`, and the new value is visible the next cycle.
- R6: Completion of the last selected channel sets the flag (`ctl_rd[2]`) and sends `conv_ch` back to the group's first channel.
- R7: `irq` is high exactly while both the flag and the interrupt enable (`ctl_rd[1]`) are 1.
- R8: A write with bit 2 clear clears the flag. A write with bit 2 set leaves the flag unchanged. A pass completing in the same cycle as a clearing write wins, and the flag is set.
- R9: A write that clears the run bit drops `conv_req` in the next cycle. A `conv_done` arriving in that same cycle stores nothing.
- R10: A start that follows a stop begins again at the group's first channel.
- R11: A single write that sets the run bit and changes the channel field starts the scan on the new selection.
- R12: A trigger pulse while the block is already running has no effect on the current channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Write data: bit0 run, bit1 irq enable, bit2 flag (0 clears), bits4:3 count, bit5 group |
| tmr_trig | input | 1 | Timer start pulse |
| ext_trig | input | 1 | External start pulse |
| ctl_rd | output | 6 | Control register contents, same layout as the write data |
| irq | output | 1 | Interrupt request (level) |
| conv_req | output | 1 | Conversion request to the converter |
| conv_ch | output | 3 | Channel being converted |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | 10 | Sample returned with completion |
| res_flat | output | 80 | Eight result slots, channel k at bits k*10 +: 10 |

## Verification
The bench runs a completion on the last channel of a pass and checks the wrap, the flag and the interrupt. A design that counted one channel too many or too few would show the wrong `conv_ch` or no flag. It also sends a completion in the same cycle as the stop write; a design that did not abort would corrupt the next channel's slot. It then restarts on the other group with a new count in one write, fires triggers while the block is running and while it is stopped, and tries both values of the flag write bit. These catch a design that restarts mid-scan, keeps the old selection, or clears the flag when it should not.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int W   = 10,
  parameter int GCH = 4,
  localparam int CW  = $clog2(GCH),
  localparam int NCH = 2 * GCH,
  localparam int CHW = CW + 1,
  localparam int CTW = CW + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTW-1:0]   ctl_wdata,
  input  logic             tmr_trig,
  input  logic             ext_trig,
  output logic [CTW-1:0]   ctl_rd,
  output logic             irq,
  output logic             conv_req,
  output logic [CHW-1:0]   conv_ch,
  input  logic             conv_done,
  input  logic [W-1:0]     conv_data,
  output logic [NCH*W-1:0] res_flat
);

  logic          start_q, ie_q, flag_q, grp_q, busy_q;
  logic [CW-1:0] cnt_q, idx_q;

  wire start_d = (ctl_we ? ctl_wdata[0] : start_q) | tmr_trig | ext_trig;
  wire rise    = start_d & ~start_q;
  wire last    = (idx_q == cnt_q);
  wire fin     = busy_q & start_d & conv_done;

  assign conv_ch  = {grp_q, idx_q};
  assign conv_req = busy_q;
  assign irq      = flag_q & ie_q;
  assign ctl_rd   = {grp_q, cnt_q, flag_q, ie_q, start_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      grp_q   <= 1'b0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      start_q <= start_d;
      if (ctl_we) begin
        ie_q  <= ctl_wdata[1];
        cnt_q <= ctl_wdata[3 +: CW];
        grp_q <= ctl_wdata[CTW-1];
      end
      if (fin && last)
        flag_q <= 1'b1;
      else if (ctl_we && !ctl_wdata[2])
        flag_q <= 1'b0;
      if (!start_d) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else if (rise) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (fin) begin
        idx_q <= last ? '0 : idx_q + 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_res
    logic [W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q <= '0;
      else if (fin && conv_ch == CHW'(k))
        slot_q <= conv_data;
    end
    assign res_flat[k*W +: W] = slot_q;
  end

endmodule

module adc_scan_seq_chk #(
  parameter int CW  = 2,
  parameter int CTW = 6,
  parameter int CHW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ctl_we,
  input logic [CTW-1:0] ctl_rd,
  input logic           irq,
  input logic           conv_req,
  input logic [CHW-1:0] conv_ch,
  input logic           conv_done
);

  a_r9_stop_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_rd[0]) |-> !conv_req);

  a_r2_start_first_ch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_rd[0]) |-> (conv_req && conv_ch[CW-1:0] == '0));

  a_r6_pass_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_done && !ctl_we && conv_ch[CW-1:0] == ctl_rd[3 +: CW]) |=> ctl_rd[2]);

  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctl_rd[1] && ctl_rd[2]));

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_done && !ctl_we) |=> conv_req);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CW(CW), .CTW(CTW), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_rd(ctl_rd), .irq(irq),
  .conv_req(conv_req), .conv_ch(conv_ch), .conv_done(conv_done)
);

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;
  localparam int W = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [5:0]  ctl_wdata = '0;
  logic        tmr_trig = 1'b0, ext_trig = 1'b0;
  logic [5:0]  ctl_rd;
  logic        irq, conv_req;
  logic [2:0]  conv_ch;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_data = '0;
  logic [79:0] res_flat;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  adc_scan_seq u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] slot(int k);
    return res_flat[k*W +: W];
  endfunction

  task automatic wr(logic [5:0] d);
    ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic conv(logic [9:0] d);
    conv_done = 1'b1; conv_data = d;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ctl", 32'(ctl_rd), 0);
    chk("R1 req", 32'(conv_req), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 res", 32'(res_flat != 0), 0);
  endtask

  task automatic t_scan3;
    wr(6'h13);
    chk("R2 req", 32'(conv_req), 1);
    chk("R2 ch", 32'(conv_ch), 0);
    conv(10'd100);
    chk("R5 slot0", 32'(slot(0)), 100);
    chk("R4 ch", 32'(conv_ch), 1);
    chk("R4 req", 32'(conv_req), 1);
    conv(10'd101);
    chk("R4 ch2", 32'(conv_ch), 2);
    chk("R6 no early flag", 32'(ctl_rd[2]), 0);
    conv(10'd102);
    chk("R5 slot2", 32'(slot(2)), 102);
    chk("R6 flag", 32'(ctl_rd[2]), 1);
    chk("R6 wrap", 32'(conv_ch), 0);
    chk("R7 irq", 32'(irq), 1);
  endtask

  task automatic t_flag;
    wr(6'h17);
    chk("R8 keep", 32'(ctl_rd[2]), 1);
    wr(6'h13);
    chk("R8 clear", 32'(ctl_rd[2]), 0);
    chk("R7 irq off", 32'(irq), 0);
  endtask

  task automatic t_abort;
    conv(10'd200);
    chk("R5 slot0 new", 32'(slot(0)), 200);
    conv_done = 1'b1; conv_data = 10'd333;
    wr(6'h12);
    conv_done = 1'b0;
    chk("R9 req", 32'(conv_req), 0);
    chk("R9 slot1", 32'(slot(1)), 101);
    chk("R9 run", 32'(ctl_rd[0]), 0);
  endtask

  task automatic t_restart;
    wr(6'h29);
    chk("R11 ch", 32'(conv_ch), 4);
    chk("R10 req", 32'(conv_req), 1);
    conv(10'd50);
    chk("R3 slot4", 32'(slot(4)), 50);
    chk("R3 ch5", 32'(conv_ch), 5);
    conv(10'd51);
    chk("R3 wrap", 32'(conv_ch), 4);
    chk("R6 flag g1", 32'(ctl_rd[2]), 1);
    chk("R7 irq disabled", 32'(irq), 0);
    conv(10'd52);
    tmr_trig = 1'b1; @(negedge clk); tmr_trig = 1'b0;
    chk("R12 ch", 32'(conv_ch), 5);
    ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
    chk("R12 ch ext", 32'(conv_ch), 5);
  endtask

  task automatic t_triggers;
    wr(6'h28);
    chk("R9 stopped", 32'(conv_req), 0);
    tmr_trig = 1'b1; @(negedge clk); tmr_trig = 1'b0;
    chk("R2 tmr run", 32'(ctl_rd[0]), 1);
    chk("R10 tmr ch", 32'(conv_ch), 4);
    wr(6'h28);
    ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
    chk("R2 ext req", 32'(conv_req), 1);
    chk("R10 ext ch", 32'(conv_ch), 4);
    wr(6'h00);
    wr(6'h01);
    chk("R3 single ch", 32'(conv_ch), 0);
    conv(10'd7);
    chk("R3 single wrap", 32'(conv_ch), 0);
    chk("R6 single flag", 32'(ctl_rd[2]), 1);
    chk("R5 slot0", 32'(slot(0)), 7);
    conv_done = 1'b1; conv_data = 10'd8;
    wr(6'h01);
    conv_done = 1'b0;
    chk("R8 set wins", 32'(ctl_rd[2]), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_scan3;
    t_flag;
    t_abort;
    t_restart;
    t_triggers;
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule